// File: doc/BRIEF.md
# Stereo Attenuation Sequencer with Soft Ramp and Auto-Mute

This block decides, for each channel of a stereo playback path, how much attenuation is applied to the audio at any moment. It takes an 8-bit attenuation request per channel, a mute request per channel, and a two-bit transition mode. It moves the applied level toward the requested level in one of four ways: at once, at the next zero crossing of that channel's signal, in 1/8 dB steps paced by the frame strobe, or in 1/8 dB steps that are each held back until a zero crossing. Whenever it waits for a crossing, a timeout forces the change if the signal never crosses.

A per-channel monitor counts runs of static samples (all zeros or all ones). A long enough run mutes that channel through the same transition rules as a volume change. One non-static sample releases the mute. A gang setting lets the first channel's request drive both channels. Each channel also has a mute pin with selectable polarity. The pin is active once the channel's level has reached the mute level, and it is also active during reset and power-down. The dB-to-gain multiplier that uses the level is outside this block.

`frame_tick` pulses for one clock per left/right frame, and `smp_a`/`smp_b` are valid while it is high. Levels come out in 1/8 dB units: the value is the code times four, and `1023` means fully muted.

Top module: `stereo_atten_ramp`

## Requirements
- R1: Attenuation code bits 7:1 give whole dB and bit 0 adds 0.5 dB. The applied level is reported in 1/8 dB units as code*4 (0 to 1020). In transition mode 2'b00 the level equals its target one clock after the target changes.
- R2: In mode 2'b01 the level changes only on a frame tick, and only when that tick carries a zero crossing. The whole change is then taken in one go. A zero crossing is either a sample equal to zero or a sample whose sign bit differs from the previous sample of the same channel. The previous sign is taken as non-negative after reset.
- R3: In mode 2'b01 or 2'b11, the change is forced on the ZX_TIMEOUT-th consecutive pending frame tick if no crossing has occurred by then.
- R4: In mode 2'b10 the level moves one 1/8 dB step toward the target on every frame tick. This gives 1 dB per 8 frames. The level does not change between ticks.
- R5: In mode 2'b11 the level moves one 1/8 dB step only on a frame tick that carries a zero crossing, or on a forced step from the timeout.
- R6: Ramp state, zero-cross history, timeout and static-run counts are kept separately for each channel.
- R7: With `am_en` high, a channel whose last AM_RUN frame samples were all 0 or all -1 targets the mute level. One non-static sample clears the condition. With `am_en` low, static samples never mute.
- R8: A mute request or an auto-mute sets the channel target to the mute level 1023. That target is reached under the same transition mode as a volume change.
- R9: With `gang` high, `code_a` sets the target of both channels and `code_b` has no effect.
- R10: A mute pin is active one clock after its channel is muted with its level at 1023, or one clock after `pwr_dn` is high. `pwr_dn` forces both levels to 1023 on the next clock. The active level equals `mute_pol` (0 = active-low).
- R11: Synchronous reset sets both levels to 1023, clears the timeouts, the run counts and the stored signs, and drives both pins to the active value `mute_pol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-clock strobe per left/right frame |
| smp_a | input | SMP_W | Channel A sample, two's complement, valid with frame_tick |
| smp_b | input | SMP_W | Channel B sample, two's complement, valid with frame_tick |
| code_a | input | 8 | Channel A attenuation code (0.5 dB units) |
| code_b | input | 8 | Channel B attenuation code (0.5 dB units) |
| mute_a | input | 1 | Channel A mute request |
| mute_b | input | 1 | Channel B mute request |
| xmode | input | 2 | Transition mode: 00 direct, 01 zero-cross, 10 ramp, 11 ramp at zero-cross |
| gang | input | 1 | Channel A code controls both channels |
| am_en | input | 1 | Auto-mute enable |
| mute_pol | input | 1 | Active level of the mute pins |
| pwr_dn | input | 1 | Power-down: force mute level and active pins |
| lvl_a | output | 10 | Channel A applied attenuation, 1/8 dB units |
| lvl_b | output | 10 | Channel B applied attenuation, 1/8 dB units |
| mute_pin_a | output | 1 | Channel A mute pin |
| mute_pin_b | output | 1 | Channel B mute pin |

## Verification
A target change and a zero crossing on the same frame tick must combine in one update. So must a timeout expiry and a crossing, and a static-run threshold and a step. The bench provokes these by changing the code or mode at a frame boundary while steering sample signs. It feeds runs of constant positive or negative samples to suppress crossings, and it feeds runs of zeros to build up auto-mute. A behavioural model running alongside predicts the level and the pins on every clock, and spot checks with values worked out by hand mark the timeout frame, the ramp positions and the release of auto-mute.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int CODE_W = 8;
  localparam int LVL_W  = CODE_W + 2;
  localparam logic [LVL_W-1:0] LVL_MUTE = '1;

  typedef enum logic [1:0] {
    XM_DIRECT  = 2'b00,
    XM_ZEROX   = 2'b01,
    XM_RAMP    = 2'b10,
    XM_RAMP_ZX = 2'b11
  } xmode_e;
endpackage

// File: rtl/zc_detect.sv
module zc_detect #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] smp,
  output logic         zc,
  output logic         is_static
);
  logic prev_neg;

  always_comb begin
    zc        = (smp == '0) || (smp[W-1] != prev_neg);
    is_static = (smp == '0) || (smp == '1);
  end

  always_ff @(posedge clk) begin
    if (rst)       prev_neg <= 1'b0;
    else if (tick) prev_neg <= smp[W-1];
  end
endmodule

// File: rtl/static_run_mon.sv
module static_run_mon #(
  parameter int RUN = 8192
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic is_static,
  output logic idle
);
  localparam int CW = $clog2(RUN + 1);
  localparam logic [CW-1:0] CMAX = CW'(RUN);
  logic [CW-1:0] cnt;

  assign idle = (cnt == CMAX);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (tick) begin
      if (!is_static)        cnt <= '0;
      else if (cnt != CMAX)  cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/atten_slew.sv
module atten_slew
  import atten_pkg::*;
#(
  parameter int TIMEOUT = 512
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             pd,
  input  logic [1:0]       mode,
  input  logic             zc,
  input  logic [LVL_W-1:0] tgt,
  output logic [LVL_W-1:0] lvl
);
  localparam int TW = $clog2(TIMEOUT);
  localparam logic [TW-1:0] TLAST = TW'(TIMEOUT - 1);

  logic [TW-1:0]    tmr;
  logic             pend, fire;
  logic [LVL_W-1:0] step_lvl;
  xmode_e           xm;

  always_comb begin
    xm       = xmode_e'(mode);
    pend     = (lvl != tgt);
    fire     = zc || (tmr == TLAST);
    step_lvl = (lvl < tgt) ? lvl + 1'b1 : lvl - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || pd) begin
      lvl <= LVL_MUTE;
      tmr <= '0;
    end else begin
      case (xm)
        XM_DIRECT: begin
          lvl <= tgt;
          tmr <= '0;
        end
        XM_RAMP: begin
          tmr <= '0;
          if (tick && pend) lvl <= step_lvl;
        end
        default: begin
          if (tick) begin
            if (!pend) begin
              tmr <= '0;
            end else if (fire) begin
              lvl <= (xm == XM_ZEROX) ? tgt : step_lvl;
              tmr <= '0;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/stereo_atten_ramp.sv
module stereo_atten_ramp
  import atten_pkg::*;
#(
  parameter int SMP_W      = 24,
  parameter int ZX_TIMEOUT = 512,
  parameter int AM_RUN     = 8192
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_tick,
  input  logic [SMP_W-1:0]  smp_a,
  input  logic [SMP_W-1:0]  smp_b,
  input  logic [CODE_W-1:0] code_a,
  input  logic [CODE_W-1:0] code_b,
  input  logic              mute_a,
  input  logic              mute_b,
  input  logic [1:0]        xmode,
  input  logic              gang,
  input  logic              am_en,
  input  logic              mute_pol,
  input  logic              pwr_dn,
  output logic [LVL_W-1:0]  lvl_a,
  output logic [LVL_W-1:0]  lvl_b,
  output logic              mute_pin_a,
  output logic              mute_pin_b
);
  localparam int NCH = 2;

  logic [SMP_W-1:0]  smp  [NCH];
  logic [CODE_W-1:0] code [NCH];
  logic              mreq [NCH];
  logic [LVL_W-1:0]  lvl  [NCH];
  logic              pin  [NCH];

  assign smp[0]  = smp_a;
  assign smp[1]  = smp_b;
  assign code[0] = code_a;
  assign code[1] = code_b;
  assign mreq[0] = mute_a;
  assign mreq[1] = mute_b;
  assign lvl_a      = lvl[0];
  assign lvl_b      = lvl[1];
  assign mute_pin_a = pin[0];
  assign mute_pin_b = pin[1];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic             zc, is_static, idle, muted, act;
    logic [CODE_W-1:0] csel;
    logic [LVL_W-1:0]  tgt;

    zc_detect #(.W(SMP_W)) u_zc (
      .clk(clk), .rst(rst), .tick(frame_tick), .smp(smp[g]),
      .zc(zc), .is_static(is_static)
    );

    static_run_mon #(.RUN(AM_RUN)) u_run (
      .clk(clk), .rst(rst), .tick(frame_tick), .is_static(is_static),
      .idle(idle)
    );

    always_comb begin
      csel  = gang ? code[0] : code[g];
      muted = mreq[g] || (am_en && idle);
      tgt   = muted ? LVL_MUTE : {csel, 2'b00};
      act   = pwr_dn || (muted && (lvl[g] == LVL_MUTE));
    end

    atten_slew #(.TIMEOUT(ZX_TIMEOUT)) u_slew (
      .clk(clk), .rst(rst), .tick(frame_tick), .pd(pwr_dn),
      .mode(xmode), .zc(zc), .tgt(tgt), .lvl(lvl[g])
    );

    always_ff @(posedge clk) begin
      if (rst) pin[g] <= mute_pol;
      else     pin[g] <= act ? mute_pol : ~mute_pol;
    end
  end
endmodule

// File: rtl/atten_chk.sv
module atten_chk #(
  parameter int LW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          frame_tick,
  input logic [1:0]    xmode,
  input logic          pwr_dn,
  input logic          mute_pol,
  input logic [LW-1:0] lvl_a,
  input logic [LW-1:0] lvl_b,
  input logic          mute_pin_a,
  input logic          mute_pin_b
);
  a_r4_single_step_a: assert property (@(posedge clk) disable iff (rst)
    (xmode == 2'b10 && !pwr_dn) |=>
      (lvl_a == $past(lvl_a) || lvl_a == $past(lvl_a) + 1'b1 || lvl_a == $past(lvl_a) - 1'b1));

  a_r4_single_step_b: assert property (@(posedge clk) disable iff (rst)
    (xmode == 2'b10 && !pwr_dn) |=>
      (lvl_b == $past(lvl_b) || lvl_b == $past(lvl_b) + 1'b1 || lvl_b == $past(lvl_b) - 1'b1));

  a_r2_tick_only_a: assert property (@(posedge clk) disable iff (rst)
    (!frame_tick && xmode != 2'b00 && !pwr_dn) |=> $stable(lvl_a));

  a_r2_tick_only_b: assert property (@(posedge clk) disable iff (rst)
    (!frame_tick && xmode != 2'b00 && !pwr_dn) |=> $stable(lvl_b));

  a_r10_pd_level: assert property (@(posedge clk) disable iff (rst)
    pwr_dn |=> (lvl_a == '1 && lvl_b == '1));

  a_r10_pd_pins: assert property (@(posedge clk) disable iff (rst)
    pwr_dn |=> (mute_pin_a == $past(mute_pol) && mute_pin_b == $past(mute_pol)));

  a_r8_pin_needs_mute_a: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(pwr_dn) && mute_pin_a == $past(mute_pol)) |-> ($past(lvl_a) == '1));

  a_r8_pin_needs_mute_b: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(pwr_dn) && mute_pin_b == $past(mute_pol)) |-> ($past(lvl_b) == '1));
endmodule

bind stereo_atten_ramp atten_chk #(.LW(atten_pkg::LVL_W)) u_chk (
  .clk(clk), .rst(rst), .frame_tick(frame_tick), .xmode(xmode),
  .pwr_dn(pwr_dn), .mute_pol(mute_pol), .lvl_a(lvl_a), .lvl_b(lvl_b),
  .mute_pin_a(mute_pin_a), .mute_pin_b(mute_pin_b)
);

// File: tb/sim_stereo_atten_ramp.sv
`timescale 1ns/1ps
module sim_stereo_atten_ramp;
  localparam int SW = 16;
  localparam int TO = 8;
  localparam int AM = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_tick = 1'b0;
  logic signed [SW-1:0] smp_a = '0, smp_b = '0;
  logic [7:0] code_a = '0, code_b = '0;
  logic mute_a = 1'b0, mute_b = 1'b0;
  logic [1:0] xmode = 2'b00;
  logic gang = 1'b0, am_en = 1'b1, mute_pol = 1'b0, pwr_dn = 1'b0;
  logic [9:0] lvl_a, lvl_b;
  logic mute_pin_a, mute_pin_b;

  int n_chk = 0, n_bad = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;
  string tag = "R11";

  // reference model state
  int m_lvl[2], m_tmr[2], m_cnt[2], m_pin[2];
  bit m_neg[2];

  always #5 clk = ~clk;

  stereo_atten_ramp #(.SMP_W(SW), .ZX_TIMEOUT(TO), .AM_RUN(AM)) u0 (
    .clk(clk), .rst(rst), .frame_tick(frame_tick), .smp_a(smp_a), .smp_b(smp_b),
    .code_a(code_a), .code_b(code_b), .mute_a(mute_a), .mute_b(mute_b),
    .xmode(xmode), .gang(gang), .am_en(am_en), .mute_pol(mute_pol), .pwr_dn(pwr_dn),
    .lvl_a(lvl_a), .lvl_b(lvl_b), .mute_pin_a(mute_pin_a), .mute_pin_b(mute_pin_b)
  );

  always @(posedge clk) begin
    for (int c = 0; c < 2; c++) begin
      int s, code, tgt;
      bit mute, zc, act;
      if (rst) begin
        m_lvl[c] = 1023; m_tmr[c] = 0; m_cnt[c] = 0; m_neg[c] = 0;
        m_pin[c] = mute_pol;
      end else begin
        s    = (c == 0) ? int'(smp_a) : int'(smp_b);
        code = gang ? int'(code_a) : ((c == 0) ? int'(code_a) : int'(code_b));
        mute = ((c == 0) ? mute_a : mute_b) || (am_en && m_cnt[c] == AM);
        tgt  = mute ? 1023 : code * 4;
        act  = pwr_dn || (mute && m_lvl[c] == 1023);
        m_pin[c] = act ? mute_pol : !mute_pol;
        zc   = (s == 0) || ((s < 0) != m_neg[c]);
        if (pwr_dn) begin
          m_lvl[c] = 1023; m_tmr[c] = 0;
        end else if (xmode == 2'b00) begin
          m_lvl[c] = tgt; m_tmr[c] = 0;
        end else if (xmode == 2'b10) begin
          m_tmr[c] = 0;
          if (frame_tick && m_lvl[c] != tgt) m_lvl[c] += (m_lvl[c] < tgt) ? 1 : -1;
        end else if (frame_tick) begin
          if (m_lvl[c] == tgt) m_tmr[c] = 0;
          else if (zc || m_tmr[c] == TO - 1) begin
            if (xmode == 2'b01) m_lvl[c] = tgt;
            else m_lvl[c] += (m_lvl[c] < tgt) ? 1 : -1;
            m_tmr[c] = 0;
          end else m_tmr[c]++;
        end
        if (frame_tick) begin
          m_neg[c] = (s < 0);
          if (s == 0 || s == -1) begin
            if (m_cnt[c] < AM) m_cnt[c]++;
          end else m_cnt[c] = 0;
        end
      end
    end
    cmp_on = 1'b1;
  end

  task automatic chk(input string t, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk({tag, " model lvl_a"}, int'(lvl_a), m_lvl[0]);
      chk({tag, " model lvl_b"}, int'(lvl_b), m_lvl[1]);
      chk({tag, " model pin_a"}, int'(mute_pin_a), m_pin[0]);
      chk({tag, " model pin_b"}, int'(mute_pin_b), m_pin[1]);
    end
  end

  task automatic frame(input int sa, input int sb);
    @(negedge clk);
    smp_a = SW'(sa); smp_b = SW'(sb); frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic frames(input int n, input int sa, input int sb);
    for (int i = 0; i < n; i++) frame(sa, sb);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R11 reset lvl_a", int'(lvl_a), 1023);
    chk("R11 reset pin_a", int'(mute_pin_a), 0);
    chk("R11 reset pin_b", int'(mute_pin_b), 0);
    rst = 1'b0;
    @(negedge clk);
    // R1: direct mode, code*4
    tag = "R1";
    code_a = 8'h05; code_b = 8'hFF;
    @(negedge clk);
    chk("R1 direct lvl_a 2.5dB", int'(lvl_a), 20);
    chk("R1 direct lvl_b 127.5dB", int'(lvl_b), 1020);
    // R2: zero-cross gated
    tag = "R2";
    xmode = 2'b01; code_a = 8'h10;
    frames(3, 1000, 1000);
    chk("R2 held without crossing", int'(lvl_a), 20);
    frame(-1000, -1000);
    chk("R2 applied at crossing", int'(lvl_a), 64);
    // R3: timeout
    tag = "R3";
    code_a = 8'h20;
    frames(TO - 1, -1000, -1000);
    chk("R3 before timeout", int'(lvl_a), 64);
    frame(-1000, -1000);
    chk("R3 forced at timeout", int'(lvl_a), 128);
    // R4/R6: soft ramp, independent channels
    tag = "R4";
    xmode = 2'b10; code_a = 8'h28; code_b = 8'h00;
    frames(10, 1000, 1000);
    chk("R4 ramp 10 steps up", int'(lvl_a), 138);
    chk("R6 ramp channel b down", int'(lvl_b), 1010);
    frames(22, 1000, 1000);
    chk("R4 ramp reaches target", int'(lvl_a), 160);
    // R5: ramp at crossings
    tag = "R5";
    xmode = 2'b11; code_a = 8'h2A;
    frame(-1000, -1000); frame(1000, 1000); frame(-1000, -1000);
    chk("R5 three crossing steps", int'(lvl_a), 163);
    frames(3, -1000, -1000);
    chk("R5 no step without crossing", int'(lvl_a), 163);
    // R9: gang
    tag = "R9";
    xmode = 2'b00; gang = 1'b1; code_a = 8'h03; code_b = 8'h40;
    @(negedge clk);
    chk("R9 gang lvl_a", int'(lvl_a), 12);
    chk("R9 gang ignores code_b", int'(lvl_b), 12);
    // R8: mute request ramps
    tag = "R8";
    xmode = 2'b10; mute_b = 1'b1;
    frames(1011, 1000, 1000);
    chk("R8 mute level reached", int'(lvl_b), 1023);
    chk("R8 pin_b active low", int'(mute_pin_b), 0);
    chk("R8 pin_a inactive", int'(mute_pin_a), 1);
    mute_b = 1'b0; xmode = 2'b00; gang = 1'b0; code_a = 8'h00; code_b = 8'h00;
    repeat (2) @(negedge clk);
    // R7: auto-mute
    tag = "R7";
    frames(AM - 1, 0, 1000);
    chk("R7 not yet muted", int'(lvl_a), 0);
    frame(0, 1000);
    chk("R7 auto-muted", int'(lvl_a), 1023);
    chk("R7 auto-mute pin", int'(mute_pin_a), 0);
    chk("R7 b unaffected", int'(lvl_b), 0);
    frame(5, 1000);
    chk("R7 released", int'(lvl_a), 0);
    frames(AM, -1, 1000);
    chk("R7 all-ones run mutes", int'(lvl_a), 1023);
    frame(5, 1000);
    am_en = 1'b0;
    frames(AM + 4, 0, 1000);
    chk("R7 disabled no mute", int'(lvl_a), 0);
    // R10: polarity and power-down
    tag = "R10";
    mute_pol = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 pin inactive high-pol", int'(mute_pin_a), 0);
    pwr_dn = 1'b1;
    @(negedge clk);
    chk("R10 pd level", int'(lvl_b), 1023);
    chk("R10 pd pin_a", int'(mute_pin_a), 1);
    chk("R10 pd pin_b", int'(mute_pin_b), 1);
    pwr_dn = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule